// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Watermark Flags

This block is an 18-bit first-in first-out buffer that sits between two unrelated clock domains. Words enter on the write clock and leave on the read clock. The storage is an inferred register array whose depth is a power of two between 256 and 4096 words. Each pointer is carried into the other domain as Gray code through a two-flop synchroniser. The full, half-full and almost-full flags are computed in the write domain. The empty and almost-empty flags are computed in the read domain.

Both data interfaces use a stream-style handshake with active-low strobes.

- **Write side.** The producer may present a word on any write-clock edge. `wr_ready` is the back-pressure signal. While `wr_ready` is low, a strobed word is dropped. The producer must hold the word and retry once `wr_ready` rises again.
- **Read side.** A read request with output enable asserted delivers the next word through `rd_data`, with `rd_valid` high for one read cycle. A read request with output enable released consumes the word without delivering it, and `rd_valid` stays low.

There are two further features:

- **Watermark registers.** Two loadable registers set how close to empty and how close to full the warning flags rise.
- **Retransmit.** A retransmit strobe rewinds the read side to storage location zero. This lets a block of data that has not yet wrapped the buffer be replayed any number of times.

Top module: `flagged_async_fifo`

## Requirements
- R1: Words that are delivered leave in the order they were written, all 18 bits intact. The depth parameter must be a power of two from 256 to 4096.
- R2: A word on `wr_data` is stored on a `wr_clk` rising edge when `wr_en_n` is 0, `ld_n` is 1 and the buffer is not full. `wr_ready` is 1 exactly when the buffer is not full.
- R3: `full_n` is 0 while DEPTH words are held. A write attempted while full is dropped, and no stored word changes.
- R4: When `rd_en_n` and `out_en_n` are both 0 on a `rd_clk` edge and the buffer is not empty, the oldest word appears on `rd_data`. `rd_valid` is 1 for the following read cycle only.
- R5: When `rd_en_n` is 0 and `out_en_n` is 1 on a `rd_clk` edge and the buffer is not empty, the oldest word is discarded. `rd_valid` stays 0.
- R6: `empty_n` is 0 while no word is held. A read attempted while empty has no effect on the read position.
- R7: `half_n` is 0 while the write-domain fill count exceeds DEPTH/2.
- R8: `afull_n` is 0 while the fill count is at least DEPTH minus the high watermark.
- R9: `aempty_n` is 0 while the read-domain fill count is at most the low watermark.
- R10: Load operation:
  - A `wr_clk` edge with `ld_n` = 0 and `wr_en_n` = 0 loads `wr_data[log2(DEPTH)-1:0]` into a watermark register and stores no word.
  - Loads alternate: the low watermark first after reset, then the high watermark, then the low one again.
- R11: A `rd_clk` edge with `rt_n` = 0 sets the read position back to location zero. This happens only if fewer than DEPTH words have been written since reset; otherwise the strobe is ignored. Retransmit takes priority over a read on the same edge.
- R12: While `rst_n` is 0, both pointers are cleared and the flags take these values: `empty_n` = 0, `aempty_n` = 0, `full_n` = 1, `half_n` = 1, `afull_n` = 1, `rd_valid` = 0. Both watermarks return to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous reset for both domains, active low |
| wr_en_n | input | 1 | Write strobe, active low |
| ld_n | input | 1 | Watermark load select, active low (qualifies `wr_en_n`) |
| wr_data | input | 18 | Write word, or watermark value in its low bits |
| wr_ready | output | 1 | High when a write would be accepted |
| rd_en_n | input | 1 | Read strobe, active low |
| out_en_n | input | 1 | Output enable, active low; high turns a read into a skip |
| rt_n | input | 1 | Retransmit strobe, active low |
| rd_data | output | 18 | Last delivered word |
| rd_valid | output | 1 | One-cycle pulse marking a delivered word |
| full_n | output | 1 | Full flag, active low |
| empty_n | output | 1 | Empty flag, active low |
| half_n | output | 1 | More-than-half-full flag, active low |
| afull_n | output | 1 | Almost-full flag, active low |
| aempty_n | output | 1 | Almost-empty flag, active low |

## Verification
The bench builds the block with DEPTH = 256, the smallest legal depth. With that depth, every fill level from 0 to 256 can be stepped through one word at a time, and every flag is compared at each level in both directions, under both the default and the loaded watermarks. The small depth also lets a single fill run wrap the write pointer. As a result, the accepted retransmit (before wrap) and the refused retransmit (after wrap) are both reached in one run. It also makes the full-state and empty-state drop cases cheap to reach.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  localparam int FIFO_DATA_W = 18;
  localparam int MIN_DEPTH = 256;
  localparam int MAX_DEPTH = 4096;
  localparam int DEFAULT_MARK = 8;

  // which watermark register the next load writes
  typedef enum logic {
    SEL_LOW_MARK  = 1'b0,
    SEL_HIGH_MARK = 1'b1
  } mark_sel_e;
endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/afifo_mem.sv
module afifo_mem #(
  parameter int DW    = 18,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/afifo_wr_ctrl.sv
module afifo_wr_ctrl
  import afifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic          ld_n,
  input  logic [AW-1:0] mark_in,
  input  logic [PW-1:0] rgray_sync,
  output logic          mem_we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          full_n,
  output logic          half_n,
  output logic          afull_n,
  output logic [AW-1:0] low_mark
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wbin, wbin_nx, rbin, fill, af_limit;
  logic [AW-1:0] high_mark;
  mark_sel_e     sel;
  logic          full, do_wr, do_ld;

  always_comb begin
    rbin     = gray_to_bin(rgray_sync);
    fill     = wbin - rbin;
    full     = (fill == DEPTH_P);
    do_wr    = !wr_en_n && ld_n && !full;
    do_ld    = !wr_en_n && !ld_n;
    wbin_nx  = wbin + PW'(do_wr);
    af_limit = DEPTH_P - {1'b0, high_mark};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin      <= '0;
      wgray     <= '0;
      sel       <= SEL_LOW_MARK;
      low_mark  <= AW'(DEFAULT_MARK);
      high_mark <= AW'(DEFAULT_MARK);
    end else begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
      if (do_ld) begin
        if (sel == SEL_LOW_MARK) low_mark  <= mark_in;
        else                     high_mark <= mark_in;
        sel <= (sel == SEL_LOW_MARK) ? SEL_HIGH_MARK : SEL_LOW_MARK;
      end
    end
  end

  assign mem_we  = do_wr;
  assign waddr   = wbin[AW-1:0];
  assign full_n  = !full;
  assign half_n  = !(fill > HALF_P);
  assign afull_n = !(fill >= af_limit);

  // R3: a write strobe while full must leave the write pointer where it was
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !wr_en_n) |=> $stable(wgray))
    else $error("write pointer moved while full");

  // R10: a watermark load never stores a word
  assert_load_no_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_n && !wr_en_n) |=> $stable(wgray))
    else $error("load advanced the write pointer");

  // R7: full implies more than half full
  assert_full_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !half_n)
    else $error("full without half flag");

  // R8: full implies almost full
  assert_full_afull_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !afull_n)
    else $error("full without almost-full flag");
endmodule

// File: rtl/afifo_rd_ctrl.sv
module afifo_rd_ctrl #(
  parameter int DEPTH = 256,
  parameter int DW    = 18,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en_n,
  input  logic          out_en_n,
  input  logic          rt_n,
  input  logic [PW-1:0] wgray_sync,
  input  logic [AW-1:0] low_mark,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          empty_n,
  output logic          aempty_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rbin, rbin_nx, wbin, fill;
  logic          wrapped, empty, rewind_ok, do_rt, do_rd, deliver;

  always_comb begin
    wbin      = gray_to_bin(wgray_sync);
    fill      = wbin - rbin;
    empty     = (fill == '0);
    rewind_ok = !(wrapped || wbin[PW-1]);
    do_rt     = !rt_n && rewind_ok;
    do_rd     = !do_rt && !rd_en_n && !empty;
    deliver   = do_rd && !out_en_n;
    rbin_nx   = do_rt ? '0 : rbin + PW'(do_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      wrapped  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= rbin_nx ^ (rbin_nx >> 1);
      rd_valid <= deliver;
      if (wbin[PW-1]) wrapped <= 1'b1;
      if (deliver) rd_data <= mem_rdata;
    end
  end

  assign raddr    = rbin[AW-1:0];
  assign empty_n  = !empty;
  assign aempty_n = !(fill <= {1'b0, low_mark});

  // R6: a read strobe while empty leaves the read pointer alone
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && !rd_en_n && rt_n) |=> $stable(rgray))
    else $error("read pointer moved while empty");

  // R5: a read with output disabled never raises valid
  assert_skip_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_n && out_en_n) |=> !rd_valid)
    else $error("valid raised on a skipped read");

  // R4: valid only follows an enabled read
  assert_valid_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!rd_en_n && !out_en_n))
    else $error("valid without an enabled read");

  // R9: empty implies almost empty
  assert_empty_aempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n)
    else $error("empty without almost-empty flag");

  // R11: after a wrap, retransmit without a read keeps the read pointer
  assert_rt_refused_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rt_n && wrapped && rd_en_n) |=> $stable(rgray))
    else $error("retransmit honoured after wrap");
endmodule

// File: rtl/flagged_async_fifo.sv
module flagged_async_fifo
  import afifo_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = FIFO_DATA_W
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en_n,
  input  logic              ld_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              rd_en_n,
  input  logic              out_en_n,
  input  logic              rt_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              full_n,
  output logic              empty_n,
  output logic              half_n,
  output logic              afull_n,
  output logic              aempty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic              mem_we;
  logic [AW-1:0]     waddr, raddr, low_mark;
  logic [PW-1:0]     wgray, rgray, wgray_sync, rgray_sync;
  logic [DATA_W-1:0] mem_rdata;

  afifo_mem #(.DW(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .wclk (wr_clk), .we (mem_we), .waddr (waddr), .wdata (wr_data),
    .raddr (raddr), .rdata (mem_rdata)
  );

  afifo_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .clk (wr_clk), .rst_n (rst_n), .wr_en_n (wr_en_n), .ld_n (ld_n),
    .mark_in (wr_data[AW-1:0]), .rgray_sync (rgray_sync),
    .mem_we (mem_we), .waddr (waddr), .wgray (wgray),
    .full_n (full_n), .half_n (half_n), .afull_n (afull_n),
    .low_mark (low_mark)
  );

  afifo_sync #(.W(PW)) u_r2w (
    .clk (wr_clk), .rst_n (rst_n), .d (rgray), .q (rgray_sync)
  );

  afifo_sync #(.W(PW)) u_w2r (
    .clk (rd_clk), .rst_n (rst_n), .d (wgray), .q (wgray_sync)
  );

  afifo_rd_ctrl #(.DEPTH(DEPTH), .DW(DATA_W), .AW(AW), .PW(PW)) u_rd (
    .clk (rd_clk), .rst_n (rst_n), .rd_en_n (rd_en_n),
    .out_en_n (out_en_n), .rt_n (rt_n), .wgray_sync (wgray_sync),
    .low_mark (low_mark), .mem_rdata (mem_rdata), .raddr (raddr),
    .rgray (rgray), .empty_n (empty_n), .aempty_n (aempty_n),
    .rd_data (rd_data), .rd_valid (rd_valid)
  );

  assign wr_ready = full_n;
endmodule

// File: tb/flagged_async_fifo_tb.sv
module flagged_async_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DEPTH      = 256;
  localparam int DW         = 18;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en_n = 1'b1, ld_n = 1'b1, rd_en_n = 1'b1, out_en_n = 1'b0, rt_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic wr_ready, rd_valid, full_n, empty_n, half_n, afull_n, aempty_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2) rd_clk = ~rd_clk;

  flagged_async_fifo #(.DEPTH(DEPTH), .DATA_W(DW)) u_dut (
    .wr_clk (wr_clk), .rd_clk (rd_clk), .rst_n (rst_n),
    .wr_en_n (wr_en_n), .ld_n (ld_n), .wr_data (wr_data), .wr_ready (wr_ready),
    .rd_en_n (rd_en_n), .out_en_n (out_en_n), .rt_n (rt_n),
    .rd_data (rd_data), .rd_valid (rd_valid), .full_n (full_n),
    .empty_n (empty_n), .half_n (half_n), .afull_n (afull_n), .aempty_n (aempty_n)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 37 + 5);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge wr_clk);
    repeat (5) @(negedge rd_clk);
  endtask

  task automatic do_write(input logic [DW-1:0] d, input logic load);
    @(negedge wr_clk);
    wr_en_n = 1'b0; ld_n = load ? 1'b0 : 1'b1; wr_data = d;
    @(negedge wr_clk);
    wr_en_n = 1'b1; ld_n = 1'b1;
  endtask

  task automatic do_read(input logic skip, output logic v, output logic [DW-1:0] d);
    @(negedge rd_clk);
    rd_en_n = 1'b0; out_en_n = skip;
    @(negedge rd_clk);
    v = rd_valid; d = rd_data;
    rd_en_n = 1'b1; out_en_n = 1'b0;
  endtask

  task automatic do_retransmit();
    @(negedge rd_clk);
    rt_n = 1'b0;
    @(negedge rd_clk);
    rt_n = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge wr_clk);
    rst_n = 1'b1;
    settle();
  endtask

  // expected flags from the fill count and the two watermarks
  task automatic check_flags(input int cnt, input int lo, input int hi);
    chk("R3 full_n", 32'(full_n), 32'(cnt != DEPTH));
    chk("R2 wr_ready", 32'(wr_ready), 32'(cnt != DEPTH));
    chk("R7 half_n", 32'(half_n), 32'(!(cnt > DEPTH / 2)));
    chk("R8 afull_n", 32'(afull_n), 32'(!(cnt >= DEPTH - hi)));
    chk("R6 empty_n", 32'(empty_n), 32'(cnt != 0));
    chk("R9 aempty_n", 32'(aempty_n), 32'(!(cnt <= lo)));
  endtask

  initial begin
    logic v;
    logic [DW-1:0] d;

    // R12: values held during reset
    repeat (3) @(negedge wr_clk);
    chk("R12 empty_n", 32'(empty_n), 32'd0);
    chk("R12 aempty_n", 32'(aempty_n), 32'd0);
    chk("R12 full_n", 32'(full_n), 32'd1);
    chk("R12 half_n", 32'(half_n), 32'd1);
    chk("R12 afull_n", 32'(afull_n), 32'd1);
    chk("R12 rd_valid", 32'(rd_valid), 32'd0);
    rst_n = 1'b1;
    settle();

    // R11: accepted retransmit before any wrap
    for (int i = 0; i < 20; i++) do_write(pat(1000 + i), 1'b0);
    settle();
    for (int i = 0; i < 5; i++) begin
      do_read(1'b0, v, d);
      chk("R4 valid", 32'(v), 32'd1);
      chk("R1 data", 32'(d), 32'(pat(1000 + i)));
    end
    do_retransmit();
    settle();
    chk("R11 refill count", 32'(aempty_n), 32'd1);
    for (int i = 0; i < 20; i++) begin
      do_read(1'b0, v, d);
      chk("R11 replay data", 32'(d), 32'(pat(1000 + i)));
    end
    settle();
    check_flags(0, 8, 8);

    // R5: skipped reads
    do_reset();
    for (int i = 0; i < 10; i++) do_write(pat(2000 + i), 1'b0);
    settle();
    for (int i = 0; i < 10; i++) begin
      do_read(i % 3 == 1, v, d);
      if (i % 3 == 1) chk("R5 skip valid", 32'(v), 32'd0);
      else begin
        chk("R4 valid", 32'(v), 32'd1);
        chk("R5 data after skip", 32'(d), 32'(pat(2000 + i)));
      end
    end
    settle();
    check_flags(0, 8, 8);

    // Fill sweep with default watermarks
    do_reset();
    for (int c = 1; c <= DEPTH; c++) begin
      do_write(pat(c - 1), 1'b0);
      settle();
      check_flags(c, 8, 8);
    end
    // R3: overflow attempt
    do_write(18'h3ABCD, 1'b0);
    settle();
    check_flags(DEPTH, 8, 8);
    // Drain sweep with periodic skips
    for (int c = DEPTH - 1; c >= 0; c--) begin
      int idx;
      idx = DEPTH - 1 - c;
      do_read(idx % 7 == 6, v, d);
      if (idx % 7 == 6) chk("R5 skip valid", 32'(v), 32'd0);
      else begin
        chk("R4 valid", 32'(v), 32'd1);
        chk("R1 order", 32'(d), 32'(pat(idx)));
      end
      settle();
      check_flags(c, 8, 8);
    end
    // R6: underflow attempt
    do_read(1'b0, v, d);
    chk("R6 empty read valid", 32'(v), 32'd0);
    do_write(18'h00155, 1'b0);
    settle();
    do_read(1'b0, v, d);
    chk("R6 pointer kept valid", 32'(v), 32'd1);
    chk("R6 pointer kept data", 32'(d), 32'h155);
    settle();
    // R11: refused after wrap
    do_retransmit();
    settle();
    chk("R11 refused empty_n", 32'(empty_n), 32'd0);

    // R10: watermark loads, low then high
    do_reset();
    do_write(18'd3, 1'b1);
    do_write(18'd5, 1'b1);
    settle();
    chk("R10 no store", 32'(empty_n), 32'd0);
    for (int c = 1; c <= DEPTH; c++) begin
      do_write(pat(c), 1'b0);
      settle();
      check_flags(c, 3, 5);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule